// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds six 32-bit counters that a processor core uses to measure its own activity. On every clock the core presents how many instructions retired in that cycle (0 to 4), a run-latch bit and a cycle tick. Two of the counters are fixed to one event each: the fifth counts retired instructions and the sixth counts ticks. The first four each pick an event through an 8-bit code held in an event-select register. The codes are decoded per counter, so a few codes are accepted only by one particular counter.

A control register holds three freeze bits: one for the whole bank, one for the four selectable counters, and one for the two fixed counters. It also holds two overflow-enable bits. When an enabled counter would reach or pass its sign bit, the counter stops at exactly 0x8000_0000 and emits a one-cycle overflow pulse. A separate block turns that pulse into an alert or an interrupt. Software reaches every counter and both configuration registers through a plain write port and a registered read port.

Top module: `perf_counter_bank`

## Requirements
- R1: After synchronous reset, all six counters, the control register, the event-select register, `rd_data` and `ovf_pulse` are zero.
- R2: Unless frozen, counter 5 (address 4) adds `retired_cnt` on every clock, and counter 6 (address 5) adds one on every clock where `clk_tick` is high. It holds when `clk_tick` is low.
- R3: Counters 1 to 4 (addresses 0 to 3) read their codes from event-select bits [31:24], [23:16], [15:8] and [7:0], in that order. Code 0x02 counts instructions and code 0x1E counts ticks. While the event-select register is all zero, none of these four counters moves.
- R4: Counter 1 also takes code 0xFE for instructions and code 0xF0 for ticks. Counter 4 also takes code 0xFA, which counts instructions only while `run_latch` is high. Code 0x02 on counter 4 ignores `run_latch`.
- R5: Control bit 0 freezes all six counters. Control bit 1 freezes counters 1 to 4. Control bit 2 freezes counters 5 and 6.
- R6: Control bit 3 enables overflow for counter 1, and control bit 4 enables it for counters 2 to 6. When an enabled counter advances by a nonzero amount to a value of 0x8000_0000 or more, it is set to exactly 0x8000_0000 and its `ovf_pulse` bit is high for the following cycle.
- R7: A counter whose overflow enable is clear wraps modulo 2^32 and never pulses.
- R8: Addresses 0 to 5 select the counters, 6 selects the control register (bits [4:0]; it reads back zero-extended) and 7 selects the event-select register. A write lands on the next clock edge. A counter write takes priority over that counter's increment in the same cycle. `rd_data` returns the addressed value one cycle after `rd_addr` is presented.
- R9: Any code other than those listed in R3 and R4 leaves its counter unchanged. This includes 0xFE or 0xF0 on counters 2 to 4 and 0xFA on counters 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retired_cnt | input | RET_W | Instructions retired this cycle |
| run_latch | input | 1 | Core run-latch state |
| clk_tick | input | 1 | Cycle event for tick-counting counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Registered read data |
| ovf_pulse | output | 6 | Per-counter overflow pulse |

## Verification
The bound checker watches every cycle for these rules:
- a counter write overrides that counter's increment;
- the global freeze keeps every counter that is not being written unchanged;
- counter 5 sums the retired counts exactly when nothing gates it;
- a pulse only appears with its enable set and with the counter sitting at 0x8000_0000.

Some behaviour can only be shown by the bench's scenarios. These are the decoding of each select field at its own position, the codes that only counters 1 and 4 accept, the run-latch gating, the group freezes, wrapping when overflow is disabled, and the read-back of the configuration registers.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int NUM_CTR = 6;
  localparam int NUM_SEL = 4;
  localparam int SEL_W   = 8;

  localparam int CTL_W        = 5;
  localparam int CTL_FRZ_ALL  = 0;
  localparam int CTL_FRZ_SEL  = 1;
  localparam int CTL_FRZ_FIX  = 2;
  localparam int CTL_OVE_C1   = 3;
  localparam int CTL_OVE_REST = 4;

  localparam int ADDR_CTL = 6;
  localparam int ADDR_EVS = 7;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_INSN  = 2'd1,
    EV_CYCLE = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/pcb_event_decode.sv
module pcb_event_decode
  import pcb_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [SEL_W-1:0] code,
  input  logic             run_latch,
  output ev_kind_t         kind
);
  logic is_insn, is_cyc;

  always_comb begin
    is_insn = (code == SEL_W'(8'h02));
    is_cyc  = (code == SEL_W'(8'h1E));
    if (IDX == 0) begin
      is_insn = is_insn || (code == SEL_W'(8'hFE));
      is_cyc  = is_cyc  || (code == SEL_W'(8'hF0));
    end
    if (IDX == 3) begin
      is_insn = is_insn || ((code == SEL_W'(8'hFA)) && run_latch);
    end
    if (is_insn)     kind = EV_INSN;
    else if (is_cyc) kind = EV_CYCLE;
    else             kind = EV_NONE;
  end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             adv,
  input  logic [INC_W-1:0] amt,
  input  logic             ovf_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse
);
  localparam logic [CNT_W:0] THRESH = {2'b01, {(CNT_W-1){1'b0}}};

  logic [CNT_W:0] sum;
  logic           clamp;

  assign sum   = {1'b0, count} + (CNT_W+1)'(amt);
  assign clamp = ovf_en && (sum >= THRESH);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= 1'b0;
      if (wr) begin
        count <= wdata;
      end else if (adv) begin
        if (clamp) begin
          count     <= THRESH[CNT_W-1:0];
          ovf_pulse <= 1'b1;
        end else begin
          count <= sum[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RET_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RET_W-1:0]   retired_cnt,
  input  logic               run_latch,
  input  logic               clk_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic [NUM_CTR-1:0] ovf_pulse
);
  localparam int EVS_USED = NUM_SEL * SEL_W;

  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] evsel_q;
  logic [CNT_W-1:0] ctr_q [NUM_CTR];
  logic             sel_any;
  logic [CNT_W-1:0] rd_mux;

  assign sel_any = (evsel_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      evsel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CTL)) ctl_q   <= wr_data[CTL_W-1:0];
      if (wr_addr == ADDR_W'(ADDR_EVS)) evsel_q <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    ev_kind_t         kind;
    logic             grp_on;
    logic [RET_W-1:0] amt;
    logic             adv;
    logic             ove;
    logic             wr_hit;

    if (i < NUM_SEL) begin : g_sel
      pcb_event_decode #(.IDX(i)) u_dec (
        .code      (evsel_q[EVS_USED-1-i*SEL_W -: SEL_W]),
        .run_latch (run_latch),
        .kind      (kind)
      );
      assign grp_on = !ctl_q[CTL_FRZ_SEL] && sel_any;
    end else begin : g_fix
      assign kind   = (i == NUM_SEL) ? EV_INSN : EV_CYCLE;
      assign grp_on = !ctl_q[CTL_FRZ_FIX];
    end

    assign ove    = (i == 0) ? ctl_q[CTL_OVE_C1] : ctl_q[CTL_OVE_REST];
    assign amt    = (kind == EV_INSN)  ? retired_cnt :
                    (kind == EV_CYCLE) ? RET_W'(clk_tick) : '0;
    assign adv    = !ctl_q[CTL_FRZ_ALL] && grp_on && (amt != '0);
    assign wr_hit = wr_en && (wr_addr == ADDR_W'(i));

    pcb_counter #(.CNT_W(CNT_W), .INC_W(RET_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .wr        (wr_hit),
      .wdata     (wr_data),
      .adv       (adv),
      .amt       (amt),
      .ovf_en    (ove),
      .count     (ctr_q[i]),
      .ovf_pulse (ovf_pulse[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_mux = ctr_q[k];
    end
    if (rd_addr == ADDR_W'(ADDR_CTL)) rd_mux = CNT_W'(ctl_q);
    if (rd_addr == ADDR_W'(ADDR_EVS)) rd_mux = evsel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RET_W  = 3,
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [CNT_W-1:0]   wr_data,
  input logic [RET_W-1:0]   retired_cnt,
  input logic [CTL_W-1:0]   ctl_q,
  input logic [CNT_W-1:0]   ctr_q [NUM_CTR],
  input logic [NUM_CTR-1:0] ovf_pulse
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    localparam int OVE_BIT = (i == 0) ? CTL_OVE_C1 : CTL_OVE_REST;

    assert_wr_wins_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en && wr_addr == ADDR_W'(i)))
        |-> ctr_q[i] == $past(wr_data));

    assert_freeze_all_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctl_q[CTL_FRZ_ALL]) && !$past(wr_en && wr_addr == ADDR_W'(i)))
        |-> ctr_q[i] == $past(ctr_q[i]));

    assert_sat_value_R6: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse[i] |-> ctr_q[i] == THRESH);

    assert_pulse_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse[i] |-> $past(ctl_q[OVE_BIT]));
  end

  assert_insn_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en && wr_addr == ADDR_W'(4)) &&
     !$past(ctl_q[CTL_FRZ_ALL] || ctl_q[CTL_FRZ_FIX] || ctl_q[CTL_OVE_REST]))
      |-> ctr_q[4] == $past(ctr_q[4]) + CNT_W'($past(retired_cnt)));
endmodule

bind perf_counter_bank pcb_checker #(.CNT_W(CNT_W), .RET_W(RET_W), .ADDR_W(ADDR_W)) u_pcb_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .retired_cnt (retired_cnt),
  .ctl_q       (ctl_q),
  .ctr_q       (ctr_q),
  .ovf_pulse   (ovf_pulse)
);

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  retired_cnt = '0;
  logic        run_latch = 1'b0;
  logic        clk_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  ovf_pulse;

  perf_counter_bank dut (
    .clk(clk), .rst(rst), .retired_cnt(retired_cnt), .run_latch(run_latch),
    .clk_tick(clk_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf_pulse(ovf_pulse)
  );

  always #10 clk = ~clk;  // 20 time units per period: 50 MHz

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int  checks = 0, failures = 0;
  int  pc[6];
  logic rd_req = 1'b0;
  logic [4:0] base = '0;
  bit  done = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per requested read and tallies pulses.
  initial begin
    for (int k = 0; k < 6; k++) pc[k] = 0;
    forever begin
      logic req;
      @(posedge clk);
      req = rd_req;
      #2;
      for (int k = 0; k < 6; k++) if (!rst && ovf_pulse[k]) pc[k]++;
      if (req) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(rd_data, it.exp, it.tag);
      end
    end
  end

  // Driver tasks start and end on a falling edge.
  task automatic wr(input int addr, input logic [31:0] data);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd_addr = 3'(addr); rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // Unfreeze for exactly n counting edges, then freeze again.
  task automatic run(input int n);
    wr(6, 32'(base));
    repeat (n - 1) @(negedge clk);
    wr(6, 32'(base | 5'd1));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(32'(ovf_pulse), 0, "R1 ovf_pulse");
    for (int a = 0; a < 8; a++) rd(a, 0, "R1 reset value");
    wr(6, 1);

    // R2: fixed counters, R3: empty select register
    retired_cnt = 3; clk_tick = 1;
    run(5);
    rd(4, 15, "R2 insn counter");
    rd(5, 5, "R2 tick counter");
    rd(0, 0, "R3 empty select holds counter 1");
    clk_tick = 0;
    run(3);
    rd(4, 24, "R2 insn counter second burst");
    rd(5, 5, "R2 tick low holds");

    // R3: field positions and base codes
    for (int a = 0; a < 4; a++) wr(a, 0);
    wr(7, 32'h021E021E);
    retired_cnt = 2; clk_tick = 1;
    run(4);
    rd(0, 8, "R3 c1 insn");
    rd(1, 4, "R3 c2 tick");
    rd(2, 8, "R3 c3 insn");
    rd(3, 4, "R3 c4 tick");
    rd(7, 32'h021E021E, "R8 select readback");

    // R4: counter-specific codes and run latch
    wr(0, 0); wr(3, 0);
    wr(7, 32'hFE0000FA);
    run_latch = 0; retired_cnt = 1;
    run(3);
    rd(0, 3, "R4 c1 code FE");
    rd(3, 0, "R4 c4 FA with run latch low");
    run_latch = 1;
    run(3);
    rd(3, 3, "R4 c4 FA with run latch high");
    wr(7, 32'hF0000002);
    run_latch = 0; retired_cnt = 2; clk_tick = 1;
    run(2);
    rd(0, 8, "R4 c1 code F0 ticks");
    rd(3, 7, "R4 c4 code 02 ignores run latch");

    // R9: unknown or misplaced codes
    for (int a = 0; a < 4; a++) wr(a, 0);
    wr(7, 32'h05F0FE1F);
    run(3);
    for (int a = 0; a < 4; a++) rd(a, 0, "R9 code ignored");

    // R5: group freezes
    for (int a = 0; a < 6; a++) wr(a, 0);
    wr(7, 32'h02020202);
    retired_cnt = 1; clk_tick = 1;
    base = 5'b00010;
    run(3);
    rd(0, 0, "R5 select group frozen c1");
    rd(3, 0, "R5 select group frozen c4");
    rd(4, 3, "R5 fixed group runs c5");
    rd(5, 3, "R5 fixed group runs c6");
    base = 5'b00100;
    run(3);
    rd(0, 3, "R5 select group runs");
    rd(4, 3, "R5 fixed group frozen c5");
    rd(5, 3, "R5 fixed group frozen c6");
    rd(6, 5, "R8 control readback");

    // R6 and R7: saturation and per-counter enables
    base = 5'b10000;
    wr(7, 32'h02000000);
    wr(0, 32'h7FFFFFFF); wr(4, 32'h7FFFFFFE); wr(5, 32'h7FFFFFFF);
    retired_cnt = 3; clk_tick = 1;
    run(1);
    rd(4, 32'h80000000, "R6 c5 clamps");
    rd(5, 32'h80000000, "R6 c6 clamps");
    rd(0, 32'h80000002, "R7 c1 passes without its enable");
    check(pc[4], 1, "R6 c5 pulse count");
    check(pc[5], 1, "R6 c6 pulse count");
    check(pc[0], 0, "R7 c1 no pulse");
    base = 5'b11000;
    wr(0, 32'h7FFFFFFE);
    p0 = pc[0];
    run(1);
    rd(0, 32'h80000000, "R6 c1 clamps with own enable");
    check(pc[0], p0 + 1, "R6 c1 pulse count");
    base = 5'b00000;
    wr(7, 32'h001E0000);
    wr(1, 32'hFFFFFFFF);
    run(2);
    rd(1, 1, "R7 c2 wraps");
    check(pc[1], 0, "R7 c2 no pulse");

    // R8: write wins over increment in the same cycle
    wr(7, 0);
    retired_cnt = 3;
    wr(6, 0);
    wr(4, 1000);
    wr(6, 1);
    rd(4, 1003, "R8 write priority");

    repeat (3) @(negedge clk);
    check(32'(sb_q.size()), 0, "R8 all reads answered");
    finish_run();
  end
endmodule